// File: doc/BRIEF.md
# Prioritized Interrupt Status and Mask Controller

This block collects thirteen level-sensitive peripheral request lines into a 32-bit status register. Each line owns one fixed bit. When a line changes level, its bit takes the new level. A 32-bit mask register selects which status bits may interrupt the processor. Software reaches both registers through a simple register bus, with combinational read data and single-cycle writes.

The status bits fall into three fixed groups. Each group stands for one processor priority level, and each level has its own autovector number. The block drives the level of the highest group that holds any pending bit, together with that group's vector.

A separate side-band strobe also writes the DMA-request bit 26. A DMA-enable control bit held elsewhere in the chip drives this strobe. The bus carries 4-byte accesses only.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Each of these request lines sets or clears one fixed status bit: srcLines[0] to bit 7, [1] to bit 3, [2] to bit 2, [3] to bit 9, [4] to bit 10, [5] to bit 12 and [6] to bit 5. These seven bits form the level-3 group, with vector 27.
- R2: srcLines[7] maps to status bit 17. It is the only member of the level-5 group, with vector 29.
- R3: The level-6 group has vector 30. Its lines map as follows: srcLines[8] to bit 28, [9] to bit 27, [10] to bit 26, [11] to bit 23 and [12] to bit 21.
- R4: In the cycle after a line changes level, its status bit equals the new level. Between changes, the bit keeps any value software wrote.
- R5: A write with busWrEn at offset 0x7000 loads the status register, and one at offset 0x7800 loads the mask register. When busAddr selects either offset, busRdata returns that register.
- R6: A pulse on sideWr loads sideVal into status bit 26.
- R7: A status bit counts as pending only while its mask bit is also 1.
- R8: irqLevel is 6, 5 or 3 for the highest group that has a pending bit, and 0 when no bit is pending. irqVector is 30, 29, 27 or 0 to match.
- R9: For a given bit, a line change beats the side-band strobe, and the side-band strobe beats a bus write to status, when they fall in the same cycle.
- R10: A write to any other offset changes neither register. A read of any other offset returns 0.
- R11: After reset, status and mask are 0, and irqLevel and irqVector are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 16 | Register byte offset |
| busWrEn | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| srcLines | input | 13 | Level-sensitive peripheral request lines |
| sideWr | input | 1 | Side-band update strobe for bit 26 |
| sideVal | input | 1 | Value loaded by sideWr |
| irqLevel | output | 3 | Requested processor priority level |
| irqVector | output | 8 | Autovector number for irqLevel |

## Verification
On every cycle, the assertions check three rules. A changed line lands in its status bit on the next edge, even against a bus write or the side-band strobe. Status and mask hold their values when nothing touches them. The level output is always legal and always agrees with the vector. Some behaviour needs the bench's scenarios instead: the exact bit for each line, the group chosen when several are pending, masking that hides a group, and offsets that are ignored. The bench checks these against its own model under directed and random stimulus.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int NUM_SRC = 13;
  localparam int REG_W   = 32;

  // control-to-datapath strobes
  typedef struct packed {
    logic               wrStatus;
    logic               wrMask;
    logic               selStatus;
    logic               selMask;
    logic               sideUpd;
    logic               sideVal;
    logic [NUM_SRC-1:0] srcChg;
    logic [NUM_SRC-1:0] srcLvl;
  } strobe_t;

  // status bit owned by each request line
  function automatic int srcBit(input int idx);
    case (idx)
      0:       return 7;
      1:       return 3;
      2:       return 2;
      3:       return 9;
      4:       return 10;
      5:       return 12;
      6:       return 5;
      7:       return 17;
      8:       return 28;
      9:       return 27;
      10:      return 26;
      11:      return 23;
      default: return 21;
    endcase
  endfunction

  // priority level requested by each request line
  function automatic int srcLevel(input int idx);
    if (idx <= 6)       return 3;
    else if (idx == 7)  return 5;
    else                return 6;
  endfunction

endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 16'h7000,
  parameter logic [ADDR_W-1:0] MASK_OFS   = 16'h7800
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [NUM_SRC-1:0] srcLines,
  input  logic               sideWr,
  input  logic               sideVal,
  output strobe_t            stb
);

  logic [NUM_SRC-1:0] prevLvl;
  logic               hitStatus;
  logic               hitMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= '0;
    else       prevLvl <= srcLines;
  end

  assign hitStatus = (busAddr == STATUS_OFS);
  assign hitMask   = (busAddr == MASK_OFS);

  always_comb begin
    stb           = '0;
    stb.selStatus = hitStatus;
    stb.selMask   = hitMask;
    stb.wrStatus  = busWrEn && hitStatus;
    stb.wrMask    = busWrEn && hitMask;
    stb.sideUpd   = sideWr;
    stb.sideVal   = sideVal;
    stb.srcChg    = srcLines ^ prevLvl;
    stb.srcLvl    = srcLines;
  end

endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int SIDE_BIT = 26,
  parameter int SIDE_SRC = 10,
  parameter int VEC_W    = 8,
  parameter int VEC_L3   = 27,
  parameter int VEC_L5   = 29,
  parameter int VEC_L6   = 30
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [REG_W-1:0] busWdata,
  output logic [REG_W-1:0] busRdata,
  output logic [2:0]       irqLevel,
  output logic [VEC_W-1:0] irqVector
);

  logic [REG_W-1:0] statusQ;
  logic [REG_W-1:0] maskQ;
  logic [REG_W-1:0] srcHit;
  logic [REG_W-1:0] srcVal;
  logic [REG_W-1:0] grp3;
  logic [REG_W-1:0] grp5;
  logic [REG_W-1:0] grp6;
  logic [REG_W-1:0] pending;

  // scatter line changes onto status bit positions
  always_comb begin
    srcHit = '0;
    srcVal = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (stb.srcChg[i]) begin
        srcHit[srcBit(i)] = 1'b1;
        srcVal[srcBit(i)] = stb.srcLvl[i];
      end
    end
  end

  // group membership masks, built from the package table
  always_comb begin
    grp3 = '0;
    grp5 = '0;
    grp6 = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (srcLevel(i) == 3)      grp3[srcBit(i)] = 1'b1;
      else if (srcLevel(i) == 5) grp5[srcBit(i)] = 1'b1;
      else                       grp6[srcBit(i)] = 1'b1;
    end
  end

  // per-bit status cell: line change > side-band > bus write > hold
  for (genvar b = 0; b < REG_W; b++) begin : g_stat
    logic sideHere;
    assign sideHere = (b == SIDE_BIT) && stb.sideUpd;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             statusQ[b] <= 1'b0;
      else if (srcHit[b])    statusQ[b] <= srcVal[b];
      else if (sideHere)     statusQ[b] <= stb.sideVal;
      else if (stb.wrStatus) statusQ[b] <= busWdata[b];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           maskQ <= '0;
    else if (stb.wrMask) maskQ <= busWdata;
  end

  assign pending = statusQ & maskQ;

  always_comb begin
    if (|(pending & grp6)) begin
      irqLevel  = 3'd6;
      irqVector = VEC_W'(VEC_L6);
    end else if (|(pending & grp5)) begin
      irqLevel  = 3'd5;
      irqVector = VEC_W'(VEC_L5);
    end else if (|(pending & grp3)) begin
      irqLevel  = 3'd3;
      irqVector = VEC_W'(VEC_L3);
    end else begin
      irqLevel  = 3'd0;
      irqVector = '0;
    end
  end

  always_comb begin
    if (stb.selStatus)    busRdata = statusQ;
    else if (stb.selMask) busRdata = maskQ;
    else                  busRdata = '0;
  end

  // assertions
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_ast
    AST_SRC_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
      stb.srcChg[i] |=> statusQ[srcBit(i)] == $past(stb.srcLvl[i])); // R9
  end

  AST_SIDE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sideUpd && !stb.srcChg[SIDE_SRC]) |=> statusQ[SIDE_BIT] == $past(stb.sideVal)); // R6

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.wrStatus && !stb.sideUpd && stb.srcChg == '0) |=> $stable(statusQ)); // R4

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrMask |=> $stable(maskQ)); // R10

  AST_LEVEL_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (irqLevel == 3'd0 || irqLevel == 3'd3 || irqLevel == 3'd5 || irqLevel == 3'd6)); // R8

  AST_LEVEL_VEC: assert property (@(posedge clk) disable iff (!rstN)
    (irqLevel == 3'd0) == (irqVector == '0)); // R8

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 16'h7000,
  parameter logic [ADDR_W-1:0] MASK_OFS   = 16'h7800,
  parameter int VEC_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [REG_W-1:0]   busWdata,
  output logic [REG_W-1:0]   busRdata,
  input  logic [NUM_SRC-1:0] srcLines,
  input  logic               sideWr,
  input  logic               sideVal,
  output logic [2:0]         irqLevel,
  output logic [VEC_W-1:0]   irqVector
);

  strobe_t stb;

  irqc_ctrl #(
    .ADDR_W(ADDR_W), .STATUS_OFS(STATUS_OFS), .MASK_OFS(MASK_OFS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .srcLines(srcLines), .sideWr(sideWr), .sideVal(sideVal), .stb(stb)
  );

  irqc_datapath #(.VEC_W(VEC_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata),
    .busRdata(busRdata), .irqLevel(irqLevel), .irqVector(irqVector)
  );

endmodule

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;

  localparam logic [15:0] ST = 16'h7000;
  localparam logic [15:0] MK = 16'h7800;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = ST;
  logic        busWrEn = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [12:0] srcLines = '0;
  logic        sideWr = 1'b0;
  logic        sideVal = 1'b0;
  logic [2:0]  irqLevel;
  logic [7:0]  irqVector;

  int checks = 0;
  int fails = 0;
  logic [31:0] mStat = '0, mMask = '0;
  logic [12:0] mPrev = '0;

  always #2.5 clk = ~clk;

  irq_prio_ctrl u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWdata(busWdata), .busRdata(busRdata), .srcLines(srcLines),
    .sideWr(sideWr), .sideVal(sideVal), .irqLevel(irqLevel), .irqVector(irqVector)
  );

  function automatic int tbBit(input int i);
    int t[13] = '{7, 3, 2, 9, 10, 12, 5, 17, 28, 27, 26, 23, 21};
    return t[i];
  endfunction

  function automatic logic [2:0] tbLevel(input logic [31:0] p);
    if (|(p & 32'h1C80_0000 | p & 32'h0020_0000)) return 3'd6;
    if (p[17]) return 3'd5;
    if (|(p & 32'h0000_16AC)) return 3'd3;
    return 3'd0;
  endfunction

  function automatic logic [7:0] tbVec(input logic [2:0] l);
    case (l)
      3'd6: return 8'd30;
      3'd5: return 8'd29;
      3'd3: return 8'd27;
      default: return 8'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    busAddr = ST; #0.5;
    chk({tag, " status"}, busRdata, mStat);
    busAddr = MK; #0.5;
    chk({tag, " mask"}, busRdata, mMask);
    chk({tag, " R8 level"}, {29'd0, irqLevel}, {29'd0, tbLevel(mStat & mMask)});
    chk({tag, " R8 vector"}, {24'd0, irqVector}, {24'd0, tbVec(tbLevel(mStat & mMask))});
  endtask

  // drive one cycle at the falling edge, update model, check at next falling edge
  task automatic cyc(input string tag, input logic wr, input logic [15:0] a,
                     input logic [31:0] d, input logic [12:0] lines,
                     input logic sw, input logic sv);
    logic [31:0] ns;
    busWrEn = wr; busAddr = a; busWdata = d; srcLines = lines;
    sideWr = sw; sideVal = sv;
    ns = mStat;
    if (wr && a == ST) ns = d;
    if (sw) ns[26] = sv;
    for (int i = 0; i < 13; i++)
      if (lines[i] != mPrev[i]) ns[tbBit(i)] = lines[i];
    if (wr && a == MK) mMask = d;
    mStat = ns;
    mPrev = lines;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0; sideWr = 1'b0;
    checkAll(tag);
  endtask

  initial begin : watchdog
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    logic [12:0] ln;
    rd = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R11 reset");

    cyc("R5 mask write", 1, MK, 32'hFFFF_FFFF, '0, 0, 0);
    cyc("R5 status write", 1, ST, 32'hDEAD_BEEF, '0, 0, 0);
    cyc("R5 status clear", 1, ST, 32'h0, '0, 0, 0);

    // each level-3 line alone
    for (int i = 0; i < 7; i++) begin
      cyc("R1 raise", 0, ST, 0, 13'(1 << i), 0, 0);
      chk("R1 bit", {31'd0, mStat[tbBit(i)]}, 32'd1);
      cyc("R4 drop", 0, ST, 0, '0, 0, 0);
    end
    cyc("R2 serial", 0, ST, 0, 13'h0080, 0, 0);
    chk("R2 level", {29'd0, irqLevel}, 32'd5);
    cyc("R4 drop", 0, ST, 0, '0, 0, 0);
    for (int i = 8; i < 13; i++) begin
      cyc("R3 raise", 0, ST, 0, 13'(1 << i) | 13'h0081, 0, 0);
      chk("R3 vector", {24'd0, irqVector}, 32'd30);
      cyc("R4 drop", 0, ST, 0, 13'h0081, 0, 0);
    end
    // all groups pending, then mask out the upper groups
    cyc("R8 all", 0, ST, 0, 13'h1FFF, 0, 0);
    cyc("R7 mask l6", 1, MK, 32'h0002_16AC, 13'h1FFF, 0, 0);
    chk("R7 level5", {29'd0, irqLevel}, 32'd5);
    cyc("R7 mask l5", 1, MK, 32'h0000_16AC, 13'h1FFF, 0, 0);
    chk("R7 level3", {29'd0, irqLevel}, 32'd3);
    cyc("R7 mask none", 1, MK, 32'h0, 13'h1FFF, 0, 0);
    chk("R7 idle", {29'd0, irqLevel}, 32'd0);
    cyc("R4 drop all", 1, MK, 32'hFFFF_FFFF, '0, 0, 0);
    // software write loses to a line change
    cyc("R9 line vs write", 1, ST, 32'h0, 13'h0001, 0, 0);
    chk("R9 bit7", {31'd0, mStat[7]}, 32'd1);
    cyc("R9 line vs side", 0, ST, 0, 13'h0401, 1, 0);
    chk("R9 bit26", {31'd0, mStat[26]}, 32'd1);
    cyc("R6 side clear", 1, ST, 32'hFFFF_FFFF, 13'h0401, 1, 0);
    chk("R6 bit26", {31'd0, mStat[26]}, 32'd0);
    cyc("R6 side set", 0, ST, 0, 13'h0401, 1, 1);
    chk("R6 bit26 set", {31'd0, mStat[26]}, 32'd1);
    // unmapped offset
    cyc("R10 ignored write", 1, 16'h7004, 32'h0, 13'h0401, 0, 0);
    busAddr = 16'h7004; #0.5;
    chk("R10 read zero", busRdata, 32'h0);

    for (int n = 0; n < 600; n++) begin
      logic wr;
      logic [15:0] a;
      ln = mPrev;
      if ($urandom_range(0, 3) == 0) ln[$urandom_range(0, 12)] ^= 1'b1;
      wr = ($urandom_range(0, 4) == 0);
      case ($urandom_range(0, 2))
        0: a = ST;
        1: a = MK;
        default: a = 16'h7400;
      endcase
      cyc("R4 random", wr, a, $urandom, ln, ($urandom_range(0, 9) == 0), 1'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule